// File: doc/BRIEF.md
# Port-Mapped Bitmap Graphics Controller

This block is a monochrome bitmap display controller that an 8-bit host reaches only through four I/O ports. Two ports hold a byte-column pointer and a row pointer. One port holds the mode bits. The fourth port is a data window onto the frame-buffer byte at the current pointer pair. Each byte holds eight adjacent pixels, and the most significant bit is the leftmost pixel. A line is 80 bytes (640 pixels) and the frame is 200 lines. After a data access, the column pointer or the row pointer can step forward by itself. This lets the host sweep a line or a column without rewriting the pointers.

A raster counter scans the on-chip frame buffer through a second RAM port. It drives a pixel output and a blanking output. To keep host traffic from disturbing the picture, a data-port access made while the raster is inside the visible area is stalled with a wait signal until horizontal or vertical blanking begins. A mode bit removes this stall. Accesses then finish at once, and the visible tearing is accepted. A short-timing build parameter shrinks each line, so that stalls and blanking can be exercised quickly in simulation.

Top module: `bitmap_port_ctrl`

## Requirements
- R1: `io_addr` selects the port: 0 is the column pointer, 1 is the row pointer, 2 is the mode register and 3 is the data window. An access is a cycle with `io_wr` or `io_rd` high. It completes on the first rising edge at which `io_wait` is low.
- R2: A value written to the column port is stored modulo 80. A value written to the row port is stored modulo 200. Reading either port returns the stored value.
- R3: A completed data write stores `io_wdata` at byte row*80+column. A completed data read presents the byte at the pointers as they stood before any step. `io_rdata` carries the last completed read from the edge that completes it onward.
- R4: Mode register bits: bit0 turns on the display, bit1 steps a pointer after data writes, bit2 steps a pointer after data reads, bit3 picks the row pointer (1) or the column pointer (0) to step, and bit4 turns off stalls. A read returns bits 7:5 as 0.
- R5: A pointer steps exactly once for each completed data access whose direction is enabled in bit1 or bit2. No pointer steps when the enable bit for that direction is 0.
- R6: A step takes the column from 79 to 0 and the row from 199 to 0. A step never changes the other pointer.
- R7: With bit4 at 0, a data access is stalled while the raster is in the visible area (column clock below the active width and line below 200). `io_wait` is high in the same cycle and stays high until blanking starts. Accesses to other ports are never stalled.
- R8: With bit4 at 1, `io_wait` stays low for every access.
- R9: Each line lasts a fixed number of clocks, the first part of which is visible, and the frame adds blank lines after line 199. `video_blank` is high for non-visible positions, two clocks after the raster position.
- R10: `video_pixel` is bit (7 - col mod 8) of the byte at (col/8, line), two clocks after the raster position. It is 0 when bit0 of the mode register is 0 or when the position is blanked.
- R11: After reset, both pointers and the mode register are 0, `io_rdata` is 0, `video_blank` is 1 and `video_pixel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 2 | Port select |
| io_rd | input | 1 | Read strobe, held until the access completes |
| io_wr | input | 1 | Write strobe, held until the access completes |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Data of the last completed read |
| io_wait | output | 1 | Stall request for the current data access |
| video_pixel | output | 1 | Serial pixel |
| video_blank | output | 1 | High outside the visible area |

## Verification
`io_wait` is a same-cycle function of the strobes and the registered raster state, so the bench samples it one time unit after each falling edge, once the inputs have settled. A read result appears on `io_rdata` after the completing edge, so the access tasks pick it up at the next falling edge. A pointer step is observed through a later read of the pointer ports. The video outputs trail the raster by two registers. The reference model therefore carries a two-stage pipe, updated at each rising edge in the same order as the hardware, and all four outputs are compared with that model at every falling edge. Stall lengths are checked against the active width minus the column clock at which the access was issued.

// File: rtl/gfx_pkg.sv
`timescale 1ns/1ps
package gfx_pkg;

  typedef enum logic [1:0] {
    PORT_COL  = 2'd0,
    PORT_ROW  = 2'd1,
    PORT_MODE = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  typedef struct packed {
    logic [2:0] spare;
    logic       no_stall;
    logic       step_row;
    logic       step_on_rd;
    logic       step_on_wr;
    logic       disp_en;
  } mode_t;

endpackage

// File: rtl/gfx_ptr_regs.sv
`timescale 1ns/1ps
module gfx_ptr_regs
  import gfx_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 200,
  parameter int XW   = $clog2(COLS),
  parameter int YW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_col,
  input  logic          ld_row,
  input  logic          ld_mode,
  input  logic [7:0]    wdata,
  input  logic          acc_rd,
  input  logic          acc_wr,
  output logic [XW-1:0] ptr_x,
  output logic [YW-1:0] ptr_y,
  output mode_t         mode
);

  logic step;
  logic [XW-1:0] col_in;
  logic [YW-1:0] row_in;

  assign step   = (acc_wr && mode.step_on_wr) || (acc_rd && mode.step_on_rd);
  assign col_in = XW'(32'(wdata) % COLS);
  assign row_in = YW'(32'(wdata) % ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_x <= '0;
      ptr_y <= '0;
      mode  <= '0;
    end else begin
      if (ld_mode) mode <= mode_t'({3'b000, wdata[4:0]});

      if (ld_col)
        ptr_x <= col_in;
      else if (step && !mode.step_row)
        ptr_x <= (ptr_x == XW'(COLS - 1)) ? '0 : ptr_x + 1'b1;

      if (ld_row)
        ptr_y <= row_in;
      else if (step && mode.step_row)
        ptr_y <= (ptr_y == YW'(ROWS - 1)) ? '0 : ptr_y + 1'b1;
    end
  end

endmodule

// File: rtl/gfx_raster.sv
`timescale 1ns/1ps
module gfx_raster #(
  parameter int H_ACTIVE = 640,
  parameter int H_TOTAL  = 800,
  parameter int V_ACTIVE = 200,
  parameter int V_TOTAL  = 225,
  parameter int HW       = $clog2(H_TOTAL),
  parameter int VW       = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          scan_active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == HW'(H_TOTAL - 1)) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == VW'(V_TOTAL - 1)) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  assign scan_active = (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE));

endmodule

// File: rtl/gfx_fbuf.sv
`timescale 1ns/1ps
module gfx_fbuf #(
  parameter int DEPTH = 16000,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_rd_en,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_rd_en) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/bitmap_port_ctrl.sv
`timescale 1ns/1ps
module bitmap_port_ctrl
  import gfx_pkg::*;
#(
  parameter int COLS          = 80,
  parameter int ROWS          = 200,
  parameter int H_BLANK_CLKS  = 160,
  parameter int V_BLANK_LINES = 25,
  parameter bit SHORT_TIMING  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       io_wait,
  output logic       video_pixel,
  output logic       video_blank
);

  localparam int H_ACTIVE = SHORT_TIMING ? 16 : COLS * 8;
  localparam int H_TOTAL  = SHORT_TIMING ? 24 : H_ACTIVE + H_BLANK_CLKS;
  localparam int V_TOTAL  = ROWS + (SHORT_TIMING ? 4 : V_BLANK_LINES);
  localparam int XW       = $clog2(COLS);
  localparam int YW       = $clog2(ROWS);
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int DEPTH    = COLS * ROWS;
  localparam int AW       = $clog2(DEPTH);

  port_e         sel;
  logic          req, data_req, done;
  logic          ld_col, ld_row, ld_mode, acc_rd, acc_wr;
  logic [XW-1:0] ptr_x;
  logic [YW-1:0] ptr_y;
  mode_t         mode;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          scan_active;
  logic [AW-1:0] host_addr, scan_addr;
  logic [7:0]    host_q, scan_q;
  logic [7:0]    reg_q;
  logic          from_ram_q;
  logic          act_q;
  logic [2:0]    bit_q;

  // host side decode and stall
  assign sel      = port_e'(io_addr);
  assign req      = io_rd || io_wr;
  assign data_req = req && (sel == PORT_DATA);
  assign io_wait  = data_req && scan_active && !mode.no_stall;
  assign done     = req && !io_wait;
  assign ld_col   = done && io_wr && (sel == PORT_COL);
  assign ld_row   = done && io_wr && (sel == PORT_ROW);
  assign ld_mode  = done && io_wr && (sel == PORT_MODE);
  assign acc_wr   = done && io_wr && (sel == PORT_DATA);
  assign acc_rd   = done && io_rd && (sel == PORT_DATA);

  gfx_ptr_regs #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) u_regs (
    .clk(clk), .rst(rst),
    .ld_col(ld_col), .ld_row(ld_row), .ld_mode(ld_mode),
    .wdata(io_wdata), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .mode(mode)
  );

  gfx_raster #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(ROWS), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_raster (
    .clk(clk), .rst(rst),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .scan_active(scan_active)
  );

  assign host_addr = AW'(ptr_y) * AW'(COLS) + AW'(ptr_x);
  assign scan_addr = scan_active ? AW'(v_cnt) * AW'(COLS) + AW'(h_cnt[HW-1:3]) : '0;

  gfx_fbuf #(.DEPTH(DEPTH), .AW(AW)) u_fbuf (
    .clk(clk),
    .a_we(acc_wr), .a_rd_en(acc_rd), .a_addr(host_addr),
    .a_wdata(io_wdata), .a_rdata(host_q),
    .b_addr(scan_addr), .b_rdata(scan_q)
  );

  // readback of the register ports
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      from_ram_q <= 1'b0;
    end else if (done && io_rd) begin
      from_ram_q <= (sel == PORT_DATA);
      unique case (sel)
        PORT_COL:  reg_q <= 8'(ptr_x);
        PORT_ROW:  reg_q <= 8'(ptr_y);
        PORT_MODE: reg_q <= mode;
        default:   reg_q <= reg_q;
      endcase
    end
  end

  assign io_rdata = from_ram_q ? host_q : reg_q;

  // two-stage video pipe: byte fetch, then bit select
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q       <= 1'b0;
      bit_q       <= '0;
      video_pixel <= 1'b0;
      video_blank <= 1'b1;
    end else begin
      act_q       <= scan_active;
      bit_q       <= h_cnt[2:0];
      video_pixel <= act_q && mode.disp_en && scan_q[3'd7 - bit_q];
      video_blank <= !act_q;
    end
  end

endmodule

// File: rtl/bitmap_port_ctrl_chk.sv
`timescale 1ns/1ps
module bitmap_port_ctrl_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 200,
  parameter int XW   = $clog2(COLS),
  parameter int YW   = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    io_addr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          io_wait,
  input logic          video_pixel,
  input logic          video_blank,
  input logic [XW-1:0] ptr_x,
  input logic [YW-1:0] ptr_y
);

  AST_STALL_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    io_wait |-> (io_addr == 2'd3 && (io_rd || io_wr))); // R7

  AST_STALL_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    io_wait |-> ##2 !video_blank); // R7

  AST_STALL_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
    io_wait |=> ($stable(ptr_x) && $stable(ptr_y))); // R5

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr_x < XW'(COLS)); // R2

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr_y < YW'(ROWS)); // R6

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    video_blank |-> !video_pixel); // R10

endmodule

bind bitmap_port_ctrl bitmap_port_ctrl_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wait(io_wait), .video_pixel(video_pixel), .video_blank(video_blank),
  .ptr_x(ptr_x), .ptr_y(ptr_y)
);

// File: tb/test_bitmap_port_ctrl.sv
`timescale 1ns/1ps
module test_bitmap_port_ctrl;

  localparam int COLS = 80;
  localparam int ROWS = 200;
  localparam int HA   = 16;
  localparam int HT   = 24;
  localparam int VT   = ROWS + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] io_addr = 2'd0;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = 8'd0;
  logic [7:0] io_rdata;
  logic       io_wait, video_pixel, video_blank;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  bitmap_port_ctrl #(.COLS(COLS), .ROWS(ROWS), .SHORT_TIMING(1'b1)) i_bitmap_port_ctrl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_wait(io_wait),
    .video_pixel(video_pixel), .video_blank(video_blank)
  );

  // ---------------- reference model ----------------
  byte unsigned m_mem [COLS*ROWS];
  int   m_h, m_v, m_x, m_y, m_ctrl, m_rdata, m_hd;
  byte unsigned m_vq;
  bit   m_act, m_pix, m_blank;

  function automatic bit model_active();
    return (m_h < HA) && (m_v < ROWS);
  endfunction

  function automatic bit model_wait();
    return (io_rd || io_wr) && io_addr == 2'd3 && model_active() && !m_ctrl[4];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_h = 0; m_v = 0; m_x = 0; m_y = 0; m_ctrl = 0; m_rdata = 0;
      m_vq = 0; m_hd = 0; m_act = 0; m_pix = 0; m_blank = 1;
    end else begin
      bit act, stall, fin, step;
      int idx;
      act   = model_active();
      stall = model_wait();
      fin   = (io_rd || io_wr) && !stall;
      m_pix   = m_act && m_ctrl[0] && m_vq[7 - m_hd];
      m_blank = !m_act;
      m_vq  = act ? m_mem[m_v*COLS + m_h/8] : 8'd0;
      m_hd  = m_h % 8;
      m_act = act;
      step  = 1'b0;
      idx   = m_y*COLS + m_x;
      if (fin) begin
        case (io_addr)
          2'd0: if (io_wr) m_x = int'(io_wdata) % COLS; else m_rdata = m_x;
          2'd1: if (io_wr) m_y = int'(io_wdata) % ROWS; else m_rdata = m_y;
          2'd2: if (io_wr) m_ctrl = int'(io_wdata) & 8'h1F; else m_rdata = m_ctrl;
          default: begin
            if (io_wr) begin m_mem[idx] = io_wdata; step = m_ctrl[1]; end
            else begin m_rdata = m_mem[idx]; step = m_ctrl[2]; end
          end
        endcase
        if (step) begin
          if (m_ctrl[3]) m_y = (m_y + 1) % ROWS;
          else m_x = (m_x + 1) % COLS;
        end
      end
      m_h = m_h + 1;
      if (m_h == HT) begin m_h = 0; m_v = (m_v + 1) % VT; end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 30) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst && !done_flag) begin
      check(io_wait == model_wait(), "R7/R8 io_wait", io_wait, model_wait());
      check(video_blank == m_blank, "R9 video_blank", video_blank, m_blank);
      check(video_pixel == m_pix, "R10 video_pixel", video_pixel, m_pix);
      check(io_rdata == 8'(m_rdata), "R3 io_rdata", io_rdata, m_rdata);
    end
  end

  task automatic xfer(input logic [1:0] a, input bit w, input logic [7:0] d,
                      output logic [7:0] q, output int waits);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = !w; io_wdata = d; waits = 0;
    #1;
    while (io_wait) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    q = io_rdata; io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q; int w;
    xfer(a, 1'b1, d, q, w);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    int w;
    xfer(a, 1'b0, 8'd0, q, w);
  endtask

  task automatic wait_pos(input int v_lo, input int v_hi, input int h);
    do begin @(negedge clk); #1; end
    while (!(m_v >= v_lo && m_v <= v_hi && m_h == h - 1));
  endtask

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'((r*7 + c*13) ^ 8'h5A);
  endfunction

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int w;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11: reset state at the ports
    check(io_rdata == 8'd0, "R11 rdata", io_rdata, 0);
    check(video_blank == 1'b1, "R11 blank", video_blank, 1);
    check(video_pixel == 1'b0, "R11 pixel", video_pixel, 0);
    rd(2'd2, q); check(q == 8'd0, "R11 R4 mode reset", q, 0);
    rd(2'd0, q); check(q == 8'd0, "R11 R1 col reset", q, 0);

    // fill frame with stepping writes, no stalls (R5 R8 R1)
    wr(2'd2, 8'h12);
    for (int r = 0; r < ROWS; r++) begin
      wr(2'd1, 8'(r)); wr(2'd0, 8'd0);
      for (int c = 0; c < COLS; c++) begin
        xfer(2'd3, 1'b1, pat(r, c), q, w);
        if (c == 40 && r == 10) check(w == 0, "R8 no stall", w, 0);
      end
    end
    rd(2'd0, q); check(q == 8'd0, "R6 col wrap", q, 0);
    rd(2'd1, q); check(q == 8'd199, "R6 no carry", q, 199);

    // R2 modulo stores
    wr(2'd0, 8'd85);  rd(2'd0, q); check(q == 8'd5, "R2 col mod", q, 5);
    wr(2'd0, 8'd255); rd(2'd0, q); check(q == 8'd15, "R2 col mod", q, 15);
    wr(2'd1, 8'd203); rd(2'd1, q); check(q == 8'd3, "R2 row mod", q, 3);

    // R4 mode readback
    wr(2'd2, 8'hFF); rd(2'd2, q); check(q == 8'h1F, "R4 mode bits", q, 8'h1F);

    // R3 R5 R6 column step on read
    wr(2'd2, 8'h14); wr(2'd0, 8'd78); wr(2'd1, 8'd5);
    rd(2'd3, q); check(q == pat(5, 78), "R3 read old ptr", q, pat(5, 78));
    rd(2'd3, q); check(q == pat(5, 79), "R5 step read", q, pat(5, 79));
    rd(2'd0, q); check(q == 8'd0, "R6 col wrap", q, 0);
    rd(2'd1, q); check(q == 8'd5, "R6 row kept", q, 5);

    // R5 R6 row step
    wr(2'd2, 8'h1C); wr(2'd0, 8'd10); wr(2'd1, 8'd198);
    rd(2'd3, q); check(q == pat(198, 10), "R5 row step", q, pat(198, 10));
    rd(2'd3, q); check(q == pat(199, 10), "R5 row step", q, pat(199, 10));
    rd(2'd3, q); check(q == pat(0, 10), "R6 row wrap", q, pat(0, 10));
    rd(2'd1, q); check(q == 8'd1, "R6 row wrap", q, 1);
    rd(2'd0, q); check(q == 8'd10, "R6 col kept", q, 10);

    // R5 no step when disabled; R3 write/read
    wr(2'd2, 8'h10); wr(2'd0, 8'd3); wr(2'd1, 8'd2);
    wr(2'd3, 8'hA5);
    rd(2'd0, q); check(q == 8'd3, "R5 no step", q, 3);
    rd(2'd3, q); check(q == 8'hA5, "R3 write then read", q, 8'hA5);
    rd(2'd0, q); check(q == 8'd3, "R5 no step on read", q, 3);

    // R7 stalled write and read in visible area
    wr(2'd2, 8'h02); wr(2'd0, 8'd20); wr(2'd1, 8'd7);
    wait_pos(0, ROWS - 2, 3);
    xfer(2'd3, 1'b1, 8'h3C, q, w);
    check(w == HA - 3, "R7 stall length wr", w, HA - 3);
    rd(2'd0, q); check(q == 8'd21, "R7 single step", q, 21);
    wr(2'd2, 8'h04); wr(2'd0, 8'd20);
    wait_pos(0, ROWS - 2, 10);
    xfer(2'd3, 1'b0, 8'd0, q, w);
    check(w == HA - 10, "R7 stall length rd", w, HA - 10);
    check(q == 8'h3C, "R7 stalled read data", q, 8'h3C);
    rd(2'd0, q); check(q == 8'd21, "R7 single step rd", q, 21);
    // R7 no stall in vertical blanking
    wait_pos(ROWS, ROWS, 3);
    xfer(2'd3, 1'b0, 8'd0, q, w);
    check(w == 0, "R7 vblank no stall", w, 0);
    // R8 stall disabled in visible area
    wr(2'd2, 8'h10);
    wait_pos(0, ROWS - 2, 2);
    xfer(2'd3, 1'b1, 8'h81, q, w);
    check(w == 0, "R8 stall off", w, 0);

    // R9 R10 display enabled over two frames
    wr(2'd2, 8'h01);
    repeat (2 * HT * VT) @(negedge clk);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule